// File: doc/BRIEF.md
# MSI interrupt message generator

This block turns interrupt events from a DMA-style controller into one of two kinds of signalling. There are two event classes: normal completion and abort/error. In legacy mode it drives a level interrupt line. In message mode it issues single-beat memory-write requests that carry a Message Signaled Interrupt. A single enable bit in a 32-bit capability/control register picks the mode. Two more registers hold the message target: a 32-bit address register, which resets into the 0xFEExxxxx interrupt window, and a 16-bit data register. A status register shows which event classes are pending, and software clears its bits by writing ones. Software reads and writes all four registers through a plain configuration port. The port decodes a 2-bit register select: 0 is control, 1 is address, 2 is data and 3 is status. Reads are combinational, and a write takes effect at the clock edge.

Events are latched as pending flags. In message mode, the generator picks the next message whenever no message is being offered. An error takes priority over a normal completion. The generator then captures the address and data and presents them on a valid/ready request port. The payload stays frozen until the handshake. The message number replaces bit 0 of the data register. When the enabled-message field is 0, that bit is 0 for every event. When the field is 1 or more, that bit is 0 for normal events and 1 for error events. Only two messages exist, so any field value above 1 acts as 1.

Back-pressure rules on the request port are as follows. Once `msg_valid` rises, `msg_valid`, `msg_addr` and `msg_data` hold until a cycle in which `msg_ready` is also high. In that cycle the request is taken, and the pending flag of the sent class clears. `msg_ready` may be high at any time. Another request can be offered at the earliest one cycle after a handshake.

Top module: `msi_irq_gen`

## Requirements
- R1: After reset, the register reads are: control 0x00020005, address 0xFEE00000, data 0, and status 0. Both `irq_line` and `msg_valid` are 0.
- R2: Control bits 16 (message enable) and 22:20 (enabled-message field) read back what was written. All other bits keep their fixed values whatever is written: bits 7:0 read 0x05, bits 15:8 read 0x00, bits 19:17 read 3'b001, and bits 31:23 read 0.
- R3: The address register stores all 32 bits. The data register stores the low 16 bits of the write data and reads them back zero-extended.
- R4: With bit 16 = 0, an event sets its status bit from the next cycle: bit 0 for normal, bit 1 for error. `irq_line` is high while any status bit is set. No request is issued.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as a clear of its own bit leaves that bit set.
- R6: With bit 16 = 1, a pending event raises `msg_valid` one cycle after its status bit is set. `msg_addr` equals the address register. `msg_data` equals the data register with bit 0 replaced by the message number. `irq_line` stays 0.
- R7: The message number is 0 for every event when bits 22:20 = 0. When bits 22:20 are 1 or more, including 3 and above, it is 1 for error events and 0 for normal events.
- R8: When both classes are pending and no request is offered, the error message is offered first.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. The handshake clears the sent class's status bit, unless a new event of that class arrives in the same cycle; in that case another message of that class follows.
- R10: An event arriving while a request is offered stays pending. Its message follows after the handshake, and the offered payload does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 address, 2 data, 3 status |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Combinational read data of the selected register |
| ev_normal | input | 1 | Normal completion event, one cycle per event |
| ev_error | input | 1 | Abort/error event, one cycle per event |
| msg_valid | output | 1 | A message write request is offered |
| msg_ready | input | 1 | The fabric accepts the offered request |
| msg_addr | output | 32 | Target address of the message write |
| msg_data | output | 16 | Data of the message write |
| irq_line | output | 1 | Level legacy interrupt |

## Verification
There are two collisions to test:
- **Event and clear in the same cycle.** An event and a status clear of the same class can land in the same cycle. This can be a write-one-to-clear in legacy mode or a request handshake in message mode. The bench drives the event pulse on the same falling edge as the clear write, or the same edge on which `msg_ready` rises. It then judges the result by reading status one cycle later and by seeing a second request of that class.
- **Event while a request is held.** A new event can arrive while a request is held by back-pressure. The bench checks that the held payload is unchanged and that the new message follows the handshake.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int CFG_AW      = 2;
  localparam int NUM_CLASSES = 2;
  localparam int CLS_NORM    = 0;
  localparam int CLS_ERR     = 1;

  typedef enum logic [CFG_AW-1:0] {
    SEL_CTRL = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_DATA = 2'd2,
    SEL_STAT = 2'd3
  } cfg_sel_e;

  localparam logic [7:0]  CAP_ID_VAL   = 8'h05;
  localparam logic [7:0]  NEXT_PTR_VAL = 8'h00;
  localparam logic [2:0]  MMC_VAL      = 3'b001;
  localparam logic [31:0] ADDR_RST_VAL = 32'hFEE0_0000;

  // control register field positions
  localparam int EN_BIT  = 16;
  localparam int MME_LSB = 20;
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
  import msi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic [NUM_CLASSES-1:0] pend,
  output logic [NUM_CLASSES-1:0] stat_clr,
  output logic                   msi_en,
  output logic [2:0]             mme,
  output logic [ADDR_W-1:0]      addr_reg,
  output logic [DATA_W-1:0]      data_reg
);
  logic wr_ctrl, wr_addr, wr_data, wr_stat;

  always_comb begin
    wr_ctrl = cfg_we && (cfg_addr == SEL_CTRL);
    wr_addr = cfg_we && (cfg_addr == SEL_ADDR);
    wr_data = cfg_we && (cfg_addr == SEL_DATA);
    wr_stat = cfg_we && (cfg_addr == SEL_STAT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msi_en   <= 1'b0;
      mme      <= 3'd0;
      addr_reg <= ADDR_RST_VAL[ADDR_W-1:0];
      data_reg <= '0;
    end else begin
      if (wr_ctrl) begin
        msi_en <= cfg_wdata[EN_BIT];
        mme    <= cfg_wdata[MME_LSB+2:MME_LSB];
      end
      if (wr_addr) addr_reg <= cfg_wdata[ADDR_W-1:0];
      if (wr_data) data_reg <= cfg_wdata[DATA_W-1:0];
    end
  end

  always_comb stat_clr = wr_stat ? cfg_wdata[NUM_CLASSES-1:0] : '0;

  always_comb begin
    unique case (cfg_addr)
      SEL_CTRL: cfg_rdata = {8'h00, 1'b0, mme, MMC_VAL, msi_en, NEXT_PTR_VAL, CAP_ID_VAL};
      SEL_ADDR: cfg_rdata = 32'(addr_reg);
      SEL_DATA: cfg_rdata = 32'(data_reg);
      default:  cfg_rdata = 32'(pend);
    endcase
  end

  // R2: writable control fields take the written value at the next cycle
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (msi_en == $past(cfg_wdata[EN_BIT]) &&
                 mme == $past(cfg_wdata[MME_LSB+2:MME_LSB])));
endmodule

// File: rtl/msi_pend_arb.sv
module msi_pend_arb
  import msi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLASSES-1:0] ev,
  input  logic [NUM_CLASSES-1:0] stat_clr,
  input  logic                   msi_en,
  input  logic [2:0]             mme,
  input  logic [ADDR_W-1:0]      addr_reg,
  input  logic [DATA_W-1:0]      data_reg,
  input  logic                   msg_ready,
  output logic [NUM_CLASSES-1:0] pend,
  output logic                   msg_valid,
  output logic [ADDR_W-1:0]      msg_addr,
  output logic [DATA_W-1:0]      msg_data
);
  localparam int IDX_W = $clog2(NUM_CLASSES);
  localparam logic [DATA_W-1:0] IDX_MASK = DATA_W'((1 << IDX_W) - 1);

  logic             out_err;
  logic             load;
  logic             sel_err;
  logic [IDX_W-1:0] idx;
  logic             fire;

  always_comb begin
    fire    = msg_valid && msg_ready;
    load    = !msg_valid && msi_en && (|pend);
    sel_err = pend[CLS_ERR];
    idx     = IDX_W'(sel_err && (mme != 3'd0));
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_pend
    logic ack;
    always_comb ack = fire && (out_err == (c == CLS_ERR));
    always_ff @(posedge clk) begin
      if (!rst_n) pend[c] <= 1'b0;
      else        pend[c] <= ev[c] || (pend[c] && !stat_clr[c] && !ack);
    end
    // R5: an event always leaves its flag set, whatever clears it that cycle
    assert_ev_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev[c] |=> pend[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      out_err   <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      out_err   <= sel_err;
      msg_addr  <= addr_reg;
      msg_data  <= (data_reg & ~IDX_MASK) | DATA_W'(idx);
    end else if (fire) begin
      msg_valid <= 1'b0;
    end
  end

  // R9: payload frozen under back-pressure
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(out_err)));

  // R8: error class wins the next offer
  assert_err_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && msi_en && pend[CLS_ERR]) |=> (msg_valid && out_err));

  // R7: with one message enabled, the index bit is always 0
  assert_fold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && msi_en && (|pend) && mme == 3'd0) |=> !msg_data[0]);
endmodule

// File: rtl/msi_irq_gen.sv
module msi_irq_gen
  import msi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_normal,
  input  logic              ev_error,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              irq_line
);
  logic [NUM_CLASSES-1:0] pend;
  logic [NUM_CLASSES-1:0] stat_clr;
  logic [NUM_CLASSES-1:0] ev;
  logic                   msi_en;
  logic [2:0]             mme;
  logic [ADDR_W-1:0]      addr_reg;
  logic [DATA_W-1:0]      data_reg;

  always_comb begin
    ev           = '0;
    ev[CLS_NORM] = ev_normal;
    ev[CLS_ERR]  = ev_error;
  end

  msi_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend(pend),
    .stat_clr(stat_clr), .msi_en(msi_en), .mme(mme),
    .addr_reg(addr_reg), .data_reg(data_reg)
  );

  msi_pend_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arb_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .stat_clr(stat_clr),
    .msi_en(msi_en), .mme(mme), .addr_reg(addr_reg), .data_reg(data_reg),
    .msg_ready(msg_ready), .pend(pend), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_comb irq_line = !msi_en && (|pend);

  // R4: a legacy-mode event reaches the interrupt line one cycle later
  assert_legacy_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_normal || ev_error) && !msi_en && !cfg_we) |=> irq_line);
endmodule

// File: tb/msi_irq_gen_tb_top.sv
module msi_irq_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ev_normal = 1'b0;
  logic        ev_error = 1'b0;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [31:0] msg_addr;
  logic [15:0] msg_data;
  logic        irq_line;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_normal(ev_normal),
    .ev_error(ev_error), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .irq_line(irq_line)
  );

  // {select, write data, expected read-back}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'd0, 32'hFFFF_FFFF, 32'h0073_0005},
    {2'd0, 32'h0000_0000, 32'h0002_0005},
    {2'd0, 32'hFF2E_FFFF, 32'h0022_0005},
    {2'd1, 32'hFEE0_1234, 32'hFEE0_1234},
    {2'd2, 32'h000A_BCD5, 32'h0000_BCD5},
    {2'd2, 32'h0000_1235, 32'h0000_1235},
    {2'd3, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic pulse(input logic n, input logic e);
    @(negedge clk);
    ev_normal = n; ev_error = e;
    @(negedge clk);
    ev_normal = 1'b0; ev_error = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cfg_read(2'd0, r); check("R1 ctrl", r, 32'h0002_0005);
    cfg_read(2'd1, r); check("R1 addr", r, 32'hFEE0_0000);
    cfg_read(2'd2, r); check("R1 data", r, 32'h0);
    cfg_read(2'd3, r); check("R1 status", r, 32'h0);
    check("R1 irq", {31'b0, irq_line}, 32'h0);
    check("R1 valid", {31'b0, msg_valid}, 32'h0);

    // R2 R3 register table
    for (int i = 0; i < NVEC; i++) begin
      cfg_write(VEC[i][65:64], VEC[i][63:32]);
      cfg_read(VEC[i][65:64], r);
      check("R2/R3 table", r, VEC[i][31:0]);
    end

    // R6 R7 R9: one message, error event folds to index 0, held under back-pressure
    cfg_write(2'd0, 32'h0001_0000);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    check("R6 valid", {31'b0, msg_valid}, 32'h1);
    check("R6 addr", msg_addr, 32'hFEE0_1234);
    check("R7 fold data", {16'b0, msg_data}, 32'h1234);
    check("R6 irq quiet", {31'b0, irq_line}, 32'h0);
    repeat (3) @(negedge clk);
    check("R9 hold valid", {31'b0, msg_valid}, 32'h1);
    check("R9 hold data", {16'b0, msg_data}, 32'h1234);
    accept();
    check("R9 valid drop", {31'b0, msg_valid}, 32'h0);
    cfg_read(2'd3, r); check("R9 status cleared", r, 32'h0);

    // R8 R7: two messages, both pending, error first with index 1
    cfg_write(2'd0, 32'h0011_0000);
    pulse(1'b1, 1'b1);
    @(negedge clk);
    check("R8 error first", {16'b0, msg_data}, 32'h1235);
    cfg_read(2'd3, r); check("R8 both pending", r, 32'h3);
    accept();
    @(negedge clk);
    check("R8 normal next valid", {31'b0, msg_valid}, 32'h1);
    check("R8 normal next data", {16'b0, msg_data}, 32'h1234);
    accept();
    cfg_read(2'd3, r); check("R8 status empty", r, 32'h0);

    // R9: new normal event in the handshake cycle keeps its flag
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R9 offer", {31'b0, msg_valid}, 32'h1);
    msg_ready = 1'b1; ev_normal = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0; ev_normal = 1'b0;
    check("R9 taken", {31'b0, msg_valid}, 32'h0);
    cfg_read(2'd3, r); check("R9 refilled status", r, 32'h1);
    @(negedge clk);
    check("R9 second offer", {31'b0, msg_valid}, 32'h1);
    check("R9 second data", {16'b0, msg_data}, 32'h1234);
    accept();

    // R10: event while a request is held
    @(negedge clk);
    pulse(1'b1, 1'b0);
    @(negedge clk);
    check("R10 normal offered", {16'b0, msg_data}, 32'h1234);
    pulse(1'b0, 1'b1);
    check("R10 payload kept", {16'b0, msg_data}, 32'h1234);
    cfg_read(2'd3, r); check("R10 both pending", r, 32'h3);
    accept();
    @(negedge clk);
    check("R10 error follows", {16'b0, msg_data}, 32'h1235);
    check("R10 error valid", {31'b0, msg_valid}, 32'h1);
    accept();

    // R7: enabled-message value above 1 acts as 1
    cfg_write(2'd0, 32'h0031_0000);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    check("R7 mme3 data", {16'b0, msg_data}, 32'h1235);
    accept();

    // R4 R5 legacy mode
    cfg_write(2'd0, 32'h0);
    pulse(1'b1, 1'b0);
    check("R4 irq high", {31'b0, irq_line}, 32'h1);
    cfg_read(2'd3, r); check("R4 status", r, 32'h1);
    @(negedge clk);
    check("R4 no request", {31'b0, msg_valid}, 32'h0);
    cfg_write(2'd3, 32'h2);
    check("R5 zero bit no effect", {31'b0, irq_line}, 32'h1);
    cfg_write(2'd3, 32'h1);
    check("R5 cleared irq", {31'b0, irq_line}, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h2; ev_error = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; ev_error = 1'b0;
    cfg_read(2'd3, r); check("R5 event beats clear", r, 32'h2);
    check("R4 irq from error", {31'b0, irq_line}, 32'h1);
    cfg_write(2'd3, 32'h3);
    cfg_read(2'd3, r); check("R5 all cleared", r, 32'h0);
    check("R4 irq low", {31'b0, irq_line}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule